// File: doc/BRIEF.md
# Skew-Adaptive Separable Anti-Alias Filter

This block removes spatial frequencies that an image warp stage would otherwise fold back as aliasing. It accepts a whole frame of 8-bit samples in raster order together with two integer skew factors, one per axis. It stores the frame, then smooths every column with a symmetric 9-tap kernel whose passband narrows as the vertical skew factor grows. The column result is rounded to 8 bits and kept. Each row of that intermediate image is then smoothed with a kernel picked by the horizontal skew factor, and the result is streamed out in raster order.

The kernels are odd-length and mirror-symmetric, so the filter adds no phase shift: output sample (x, y) is centred on input sample (x, y). The kernels come from a constant table with one entry per skew factor, 1 to 16. Skew factor 1 gives a unit impulse, so that axis passes through unchanged. New skew factors may be given with every frame.

Top module: `skew_lpf`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_last` is 0.
- R2: While `in_ready` is 1, a sample is taken on every clock edge where `in_valid` is 1. Samples are taken in raster order, x first. After the IMG_W*IMG_H-th sample, `in_ready` drops to 0. It returns to 1 only in the cycle that shows the last output sample, so no input is taken while the output stream is running.
- R3: The skew factors are sampled together with the first sample of a frame. Changing `skew_x` or `skew_y` later in the same frame has no effect on that frame's output.
- R4: A skew factor of 0 is treated as 1. A skew factor above 16 is treated as 16.
- R5: For skew factor m, let the weight at tap distance k (k = 0..4) be v(k) = max(0, m-k), and let S = v(0) + 2*(v(1)+v(2)+v(3)+v(4)). The signed Q1.15 coefficient is floor(v(k)*32768/S), limited to 32767. The same coefficient is used for both taps at distance k.
- R6: The column pass uses the coefficients for `skew_y`. The row pass uses the coefficients for `skew_x`. With both factors equal to 1, the output equals the input.
- R7: The column pass runs over the whole frame first. Each of its results is rounded and saturated to 8 bits and stored. The row pass then filters those stored 8-bit values.
- R8: A tap that falls outside the image takes the value of the nearest edge sample in the same column (column pass) or the same row (row pass).
- R9: Each pass forms acc = sum of coefficient*sample and outputs floor((acc + 16384) / 32768), clamped to the range 0..255.
- R10: The output is IMG_W*IMG_H samples in raster order. Output (x, y) is centred on input (x, y). The samples come with `out_valid` high on consecutive cycles. `out_last` is 1 only with the final sample, and `out_valid` is 0 in the cycle after it.
- R11: Frames can follow one another, each with its own skew factors. A frame's result does not depend on earlier frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_pix | input | 8 | Input sample |
| skew_x | input | 5 | Horizontal skew factor, sets the row-pass cutoff |
| skew_y | input | 5 | Vertical skew factor, sets the column-pass cutoff |
| in_ready | output | 1 | Block is taking input samples |
| out_valid | output | 1 | Output sample present |
| out_pix | output | 8 | Filtered sample |
| out_last | output | 1 | Final sample of the frame |

## Verification
Vertical stripes are run with only the column pass active, and horizontal stripes with only the row pass active. Both must come out unchanged, which separates the two axes and catches swapped skew inputs. A centred impulse exposes each coefficient and its symmetric placement, so it shows both zero phase and the kernel table. A ramp and pseudo-random content at large skew factors reach the clamped image borders and test rounding of the stored intermediate. A constant image shows the overall gain. Skew values of 0 and 31, a skew change in the middle of a frame, and back-to-back frames with different factors cover clamping, sampling at frame start and independence between frames.

// File: rtl/skew_lpf.sv
module skew_lpf #(
  parameter int IMG_W    = 16,
  parameter int IMG_H    = 8,
  parameter int TAPS     = 9,
  parameter int MAX_SKEW = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_pix,
  input  logic [4:0] skew_x,
  input  logic [4:0] skew_y,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_pix,
  output logic       out_last
);
  localparam int N    = IMG_W * IMG_H;
  localparam int HALF = (TAPS - 1) / 2;
  localparam int CW   = (N > 1) ? $clog2(N) : 1;
  localparam int XW   = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int YW   = (IMG_H > 1) ? $clog2(IMG_H) : 1;
  localparam int SW   = $clog2(MAX_SKEW + 1);

  typedef enum logic [1:0] {S_LOAD, S_VERT, S_HORZ} phase_t;

  function automatic int coef_f(int m, int k);
    int s, vk, c;
    s = 0;
    for (int j = 0; j <= HALF; j++)
      s += ((m - j > 0) ? (m - j) : 0) * ((j == 0) ? 1 : 2);
    vk = (m - k > 0) ? (m - k) : 0;
    c  = (vk * 32768) / s;
    return (c > 32767) ? 32767 : c;
  endfunction

  function automatic logic [SW-1:0] clamp_skew(logic [4:0] s);
    if (s == 0) return SW'(1);
    if (int'(s) > MAX_SKEW) return SW'(MAX_SKEW);
    return SW'(s);
  endfunction

  logic signed [15:0] rom [1:MAX_SKEW][0:HALF];

  for (genvar m = 1; m <= MAX_SKEW; m++) begin : g_skew
    for (genvar k = 0; k <= HALF; k++) begin : g_tap
      assign rom[m][k] = 16'(coef_f(m, k));
    end
  end

  phase_t        state;
  logic [XW-1:0] xc;
  logic [YW-1:0] yc;
  logic [SW-1:0] sx, sy;
  logic [7:0]    buf_a [N];
  logic [7:0]    buf_b [N];
  logic [7:0]    filt;
  logic          at_first, at_last;
  logic [CW-1:0] addr;

  assign in_ready = (state == S_LOAD);
  assign at_first = (xc == '0) && (yc == '0);
  assign at_last  = (int'(xc) == IMG_W - 1) && (int'(yc) == IMG_H - 1);
  assign addr     = CW'(int'(yc) * IMG_W + int'(xc));

  always_comb begin
    int acc, lo, hi, c, pa, pb, rnd;
    acc = 0;
    for (int j = 0; j <= HALF; j++) begin
      if (state == S_VERT) begin
        pa = int'(yc) - j;
        pb = int'(yc) + j;
        if (pa < 0) pa = 0;
        if (pb > IMG_H - 1) pb = IMG_H - 1;
        lo = int'(buf_a[CW'(pa * IMG_W + int'(xc))]);
        hi = int'(buf_a[CW'(pb * IMG_W + int'(xc))]);
        c  = int'(rom[sy][j]);
      end else begin
        pa = int'(xc) - j;
        pb = int'(xc) + j;
        if (pa < 0) pa = 0;
        if (pb > IMG_W - 1) pb = IMG_W - 1;
        lo = int'(buf_b[CW'(int'(yc) * IMG_W + pa)]);
        hi = int'(buf_b[CW'(int'(yc) * IMG_W + pb)]);
        c  = int'(rom[sx][j]);
      end
      acc += c * ((j == 0) ? lo : (lo + hi));
    end
    rnd = (acc + 16384) >>> 15;
    if (rnd < 0) rnd = 0;
    if (rnd > 255) rnd = 255;
    filt = 8'(rnd);
  end

  always_ff @(posedge clk) begin
    if (state == S_LOAD && in_valid) buf_a[addr] <= in_pix;
    if (state == S_VERT) buf_b[addr] <= filt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_LOAD;
      xc        <= '0;
      yc        <= '0;
      sx        <= SW'(1);
      sy        <= SW'(1);
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if ((state == S_LOAD && in_valid) || state != S_LOAD) begin
        if (int'(xc) == IMG_W - 1) begin
          xc <= '0;
          yc <= (int'(yc) == IMG_H - 1) ? '0 : yc + 1'b1;
        end else begin
          xc <= xc + 1'b1;
        end
      end
      case (state)
        S_LOAD: if (in_valid) begin
          if (at_first) begin
            sx <= clamp_skew(skew_x);
            sy <= clamp_skew(skew_y);
          end
          if (at_last) state <= S_VERT;
        end
        S_VERT: if (at_last) state <= S_HORZ;
        default: begin
          out_pix   <= filt;
          out_valid <= 1'b1;
          out_last  <= at_last;
          if (at_last) state <= S_LOAD;
        end
      endcase
    end
  end
endmodule

module skew_lpf_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_last
);
  // R10
  burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid);
  // R10
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
  // R10
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R2
  no_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> !in_ready);
  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));
endmodule

bind skew_lpf skew_lpf_chk u_skew_lpf_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_last(out_last)
);

// File: tb/test_skew_lpf.sv
module test_skew_lpf;
  localparam int W = 16;
  localparam int H = 8;
  localparam int N = W * H;

  // mx, my, pattern kind, seed
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{1, 1, 5, 3},
    '{1, 8, 2, 0},
    '{8, 1, 3, 0},
    '{2, 2, 1, 0},
    '{4, 9, 4, 0},
    '{16, 16, 5, 7},
    '{0, 31, 5, 9},
    '{3, 5, 0, 200}
  };

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [7:0] in_pix = 0;
  logic [4:0] skew_x = 1, skew_y = 1;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_pix;

  int checks = 0, failures = 0;
  bit done = 0;
  int img [N];
  int mid [N];
  int expv [N];

  always #2 clk = ~clk;

  skew_lpf i_skew_lpf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .skew_x(skew_x), .skew_y(skew_y), .in_ready(in_ready),
    .out_valid(out_valid), .out_pix(out_pix), .out_last(out_last)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(int s);
    return (s < 1) ? 1 : ((s > 16) ? 16 : s);
  endfunction

  function automatic int wt(int m, int d);
    int sum = 0, c;
    for (int k = -4; k <= 4; k++) sum += (m - (k < 0 ? -k : k) > 0) ? m - (k < 0 ? -k : k) : 0;
    c = (((m - d > 0) ? m - d : 0) * 32768) / sum;
    return (c > 32767) ? 32767 : c;
  endfunction

  function automatic int rsat(int acc);
    int r = (acc + 16384) >>> 15;
    return (r < 0) ? 0 : ((r > 255) ? 255 : r);
  endfunction

  function automatic int pat(int kind, int x, int y, int seed);
    case (kind)
      0: return seed & 255;
      1: return (x == W / 2 && y == H / 2) ? 255 : 0;
      2: return (x % 2) ? 200 : 20;
      3: return (y % 2) ? 230 : 10;
      4: return x * 15 + y * 3;
      default: return ((x * 37 + y * 91 + seed * 13) ^ (x * y * 7)) & 255;
    endcase
  endfunction

  task automatic model(int mx, int my);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        int acc = 0;
        for (int d = -4; d <= 4; d++) begin
          int yy = y + d;
          yy = (yy < 0) ? 0 : ((yy > H - 1) ? H - 1 : yy);
          acc += wt(my, d < 0 ? -d : d) * img[yy * W + x];
        end
        mid[y * W + x] = rsat(acc);
      end
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        int acc = 0;
        for (int d = -4; d <= 4; d++) begin
          int xx = x + d;
          xx = (xx < 0) ? 0 : ((xx > W - 1) ? W - 1 : xx);
          acc += wt(mx, d < 0 ? -d : d) * mid[y * W + xx];
        end
        expv[y * W + x] = rsat(acc);
      end
  endtask

  task automatic run_frame(int mx, int my, int kind, int seed, bit disturb, string tag);
    int k = 0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) img[y * W + x] = pat(kind, x, y, seed);
    model(eff(mx), eff(my));
    skew_x = 5'(mx);
    skew_y = 5'(my);
    for (int i = 0; i < N; i++) begin
      while (!in_ready) @(negedge clk);
      in_valid = 1;
      in_pix = 8'(img[i]);
      @(negedge clk);
      if (disturb && i == 0) begin
        skew_x = 5'd16;
        skew_y = 5'd16;
      end
    end
    in_valid = 0;
    check({tag, " R2 ready low after frame"}, int'(in_ready), 0);
    while (k < N) begin
      if (out_valid) begin
        check({tag, " R10 last flag"}, int'(out_last), (k == N - 1) ? 1 : 0);
        check({tag, " R6/R7/R8/R9 pixel"}, int'(out_pix), expv[k]);
        k++;
      end
      if (k < N) @(negedge clk);
    end
    @(negedge clk);
    check({tag, " R10 valid ends"}, int'(out_valid), 0);
    check({tag, " R2 ready back"}, int'(in_ready), 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 ready in reset", int'(in_ready), 1);
    check("R1 valid in reset", int'(out_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 last after reset", int'(out_last), 0);

    // R4 R5 R11: table of frames back to back, each with its own skew
    for (int v = 0; v < NV; v++)
      run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 0, "table");

    // R6: identity, stripes untouched by the inactive/orthogonal pass
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) img[y * W + x] = pat(2, x, y, 0);
    model(1, 8);
    check("R6 vertical stripes unchanged by column pass", expv[5], img[5]);
    model(1, 1);
    check("R6 identity model", expv[W + 3], img[W + 3]);

    // R3: skew changed after first sample must not matter
    run_frame(1, 1, 5, 11, 1, "R3 mid-frame change");
    // R4: out-of-range skew values
    run_frame(0, 0, 1, 0, 0, "R4 zero skew");
    run_frame(31, 20, 1, 0, 0, "R4 large skew");
    // R8: ramp with wide kernel reaches borders
    run_frame(9, 12, 4, 0, 0, "R8 border");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule